// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading page table entries from memory, one 64-bit entry per level, over four levels. A walk begins from a root table base supplied with the request. At every level a 9-bit slice of the virtual address picks one of 512 entries. The walker forms the entry address, applies a global address mask to it, and issues a single read. It then inspects the returned entry. Each walk ends in one of two ways: a physical address with a page-size flag, or a fault.

Each entry carries flag bits in its low twelve bits. It also carries a no-execute bit at the top and an eleven-bit software field just below that. The walker removes all of these before it uses an entry as the next table base or as a frame address, so attribute bits never leak into an address. A present directory entry with its page-size bit set ends the walk early with a 2 MB page. A page-size bit at the level above the directory is reported as a fault.

A client offers a walk while `walk_ready` is high and collects the result on the one-cycle `done_valid` pulse. The memory side sees one request pulse per fetch. It must answer each request with a `mem_rsp_valid` pulse in some later cycle.

Top module: `pt_walker`

## Requirements
- R1: The table index used at each level is a 9-bit field of the virtual address: bits 47:39 for the top level, 38:30 for the third level, 29:21 for the directory level and 20:12 for the final table. The levels are fetched in that order.
- R2: Every fetch address is the current table base plus eight times the level index, bitwise ANDed with `a20_mask`. Every fetch address is therefore a multiple of 8.
- R3: Before an entry, or the root base, is used as a table base or frame address, bits 11:0, bits 62:52 and bit 63 are cleared.
- R4: If bit 0 (present) of a returned entry is 0 at any level, the walk ends with `done_fault`=1 and no further fetch is issued.
- R5: A present directory-level entry with bit 7 (page size) set ends the walk after three fetches with `done_large`=1. `done_pa` is then the cleaned entry with bits 20:0 cleared, ORed with virtual address bits 20:0.
- R6: A walk that reaches the final table makes four fetches and ends with `done_large`=0. `done_pa` is then the cleaned final entry ORed with virtual address bits 11:0.
- R7: A present third-level entry with bit 7 set ends the walk after two fetches with `done_fault`=1.
- R8: A walk is accepted only on a cycle where both `walk_valid` and `walk_ready` are 1. `walk_valid` while busy has no effect on the fetches or the result. At most one read is outstanding, and `mem_req` is a single-cycle pulse.
- R9: After reset `walk_ready`=1, `mem_req`=0 and `done_valid`=0. `done_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid | input | 1 | Start a walk |
| walk_va | input | 48 | Virtual address to translate |
| root_base | input | 64 | Base of the top-level table |
| a20_mask | input | 64 | Mask ANDed into every fetch address |
| walk_ready | output | 1 | Walker idle, can accept a walk |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 64 | Entry address for the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_large | output | 1 | Result is a 2 MB page |
| done_pa | output | 64 | Translated physical address |

## Verification
Walks are run with every entry carrying the no-execute bit, the software field and low flag bits, as well as with clean entries. Only correct stripping then yields the expected fetch addresses and frame. Translations to 4 KB and 2 MB pages are compared against each other; the 2 MB frame carries junk in bits 20:12 so that its alignment shows. Faults are placed at the top, directory and leaf levels, and at a third-level large-page entry. Each is told apart by the count and addresses of the fetches that were made. Separate cases apply an address mask that removes a set bit, and offer a second walk while one is in flight.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT  = 2'd2
   } walk_state_e;

   localparam int ENT_PRESENT_BIT = 0;
   localparam int ENT_PSIZE_BIT   = 7;
endpackage

// File: rtl/pt_idx_sel.sv
module pt_idx_sel #(
   parameter int VPN_W  = 36,
   parameter int IDX_W  = 9,
   parameter int LEVELS = 4,
   parameter int LVL_W  = 2
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [LVL_W-1:0] lvl,
   output logic [IDX_W-1:0] idx
);
   logic [IDX_W-1:0] slice [LEVELS];

   for (genvar l = 0; l < LEVELS; l++) begin : g_slice
      assign slice[l] = vpn[l*IDX_W +: IDX_W];
   end

   always_comb begin
      idx = '0;
      for (int l = 0; l < LEVELS; l++) begin
         if (lvl == LVL_W'(l)) idx = slice[l];
      end
   end
endmodule

// File: rtl/pt_entry_clean.sv
module pt_entry_clean #(
   parameter int ADDR_W     = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int SW_LO      = 52,
   parameter int SW_HI      = 62,
   parameter int NX_BIT     = 63
) (
   input  logic [ADDR_W-1:0] entry,
   output logic [ADDR_W-1:0] base
);
   logic [ADDR_W-1:0] keep;

   for (genvar b = 0; b < ADDR_W; b++) begin : g_keep
      if (b < PAGE_SHIFT) begin : g_flag
         assign keep[b] = 1'b0;
      end else if (b >= SW_LO && b <= SW_HI) begin : g_sw
         assign keep[b] = 1'b0;
      end else if (b == NX_BIT) begin : g_nx
         assign keep[b] = 1'b0;
      end else begin : g_addr
         assign keep[b] = 1'b1;
      end
   end

   assign base = entry & keep;
endmodule

// File: rtl/pt_fetch_addr.sv
module pt_fetch_addr #(
   parameter int ADDR_W   = 64,
   parameter int IDX_W    = 9,
   parameter int ENT_LG   = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic [ADDR_W-1:0] a20_mask,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] offs;

   assign offs = ADDR_W'(idx) << ENT_LG;
   assign addr = (base + offs) & a20_mask;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walk_pkg::*;
#(
   parameter int VA_W       = 48,
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 9,
   parameter int PAGE_SHIFT = 12,
   parameter int LEVELS     = 4,
   parameter int ENT_LG     = 3,
   parameter int SW_LO      = 52,
   parameter int SW_HI      = 62,
   parameter int NX_BIT     = 63,
   parameter int LARGE_LVL  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              walk_valid,
   input  logic [VA_W-1:0]   walk_va,
   input  logic [ADDR_W-1:0] root_base,
   input  logic [ADDR_W-1:0] a20_mask,
   output logic              walk_ready,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              done_valid,
   output logic              done_fault,
   output logic              done_large,
   output logic [ADDR_W-1:0] done_pa
);
   localparam int LVL_W       = $clog2(LEVELS);
   localparam int VPN_W       = VA_W - PAGE_SHIFT;
   localparam int LARGE_SHIFT = PAGE_SHIFT + IDX_W * LARGE_LVL;
   localparam int HUGE_LVL    = LARGE_LVL + 1;
   localparam logic [ADDR_W-1:0] PG_OFS =
      {{(ADDR_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
   localparam logic [ADDR_W-1:0] LG_OFS =
      {{(ADDR_W-LARGE_SHIFT){1'b0}}, {LARGE_SHIFT{1'b1}}};

   if (VPN_W != LEVELS * IDX_W) begin : g_bad_split
      $error("pt_walker: VA_W must equal PAGE_SHIFT + LEVELS*IDX_W");
   end
   if (ADDR_W < VA_W) begin : g_bad_addr
      $error("pt_walker: ADDR_W must not be narrower than VA_W");
   end
   if (LARGE_LVL < 1 || HUGE_LVL >= LEVELS) begin : g_bad_large
      $error("pt_walker: LARGE_LVL out of range");
   end
   if (NX_BIT >= ADDR_W || SW_HI >= ADDR_W || SW_LO > SW_HI) begin : g_bad_attr
      $error("pt_walker: attribute bit positions out of range");
   end

   walk_state_e       state_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [VA_W-1:0]   va_q;
   logic [ADDR_W-1:0] base_q;

   logic [IDX_W-1:0]  cur_idx;
   logic [ADDR_W-1:0] root_clean;
   logic [ADDR_W-1:0] rsp_clean;
   logic [ADDR_W-1:0] va_ext;
   logic              rsp_present;
   logic              rsp_psize;

   pt_idx_sel #(
      .VPN_W (VPN_W),
      .IDX_W (IDX_W),
      .LEVELS(LEVELS),
      .LVL_W (LVL_W)
   ) u_idx (
      .vpn(va_q[VA_W-1:PAGE_SHIFT]),
      .lvl(lvl_q),
      .idx(cur_idx)
   );

   pt_entry_clean #(
      .ADDR_W    (ADDR_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .SW_LO     (SW_LO),
      .SW_HI     (SW_HI),
      .NX_BIT    (NX_BIT)
   ) u_clean_root (
      .entry(root_base),
      .base (root_clean)
   );

   pt_entry_clean #(
      .ADDR_W    (ADDR_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .SW_LO     (SW_LO),
      .SW_HI     (SW_HI),
      .NX_BIT    (NX_BIT)
   ) u_clean_rsp (
      .entry(mem_rsp_data),
      .base (rsp_clean)
   );

   pt_fetch_addr #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W),
      .ENT_LG(ENT_LG)
   ) u_fetch (
      .base    (base_q),
      .idx     (cur_idx),
      .a20_mask(a20_mask),
      .addr    (mem_addr)
   );

   assign rsp_present = mem_rsp_data[ENT_PRESENT_BIT];
   assign rsp_psize   = mem_rsp_data[ENT_PSIZE_BIT];
   assign va_ext      = {{(ADDR_W-VA_W){1'b0}}, va_q};
   assign walk_ready  = (state_q == WK_IDLE);
   assign mem_req     = (state_q == WK_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= WK_IDLE;
         lvl_q      <= '0;
         va_q       <= '0;
         base_q     <= '0;
         done_valid <= 1'b0;
         done_fault <= 1'b0;
         done_large <= 1'b0;
         done_pa    <= '0;
      end else begin
         done_valid <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (walk_valid) begin
                  va_q    <= walk_va;
                  base_q  <= root_clean;
                  lvl_q   <= LVL_W'(LEVELS - 1);
                  state_q <= WK_ISSUE;
               end
            end
            WK_ISSUE: begin
               state_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!rsp_present) begin
                     done_valid <= 1'b1;
                     done_fault <= 1'b1;
                     done_large <= 1'b0;
                     done_pa    <= '0;
                     state_q    <= WK_IDLE;
                  end else if (lvl_q == LVL_W'(HUGE_LVL) && rsp_psize) begin
                     done_valid <= 1'b1;
                     done_fault <= 1'b1;
                     done_large <= 1'b0;
                     done_pa    <= '0;
                     state_q    <= WK_IDLE;
                  end else if (lvl_q == LVL_W'(LARGE_LVL) && rsp_psize) begin
                     done_valid <= 1'b1;
                     done_fault <= 1'b0;
                     done_large <= 1'b1;
                     done_pa    <= (rsp_clean & ~LG_OFS) | (va_ext & LG_OFS);
                     state_q    <= WK_IDLE;
                  end else if (lvl_q == '0) begin
                     done_valid <= 1'b1;
                     done_fault <= 1'b0;
                     done_large <= 1'b0;
                     done_pa    <= rsp_clean | (va_ext & PG_OFS);
                     state_q    <= WK_IDLE;
                  end else begin
                     base_q  <= rsp_clean;
                     lvl_q   <= lvl_q - 1'b1;
                     state_q <= WK_ISSUE;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int VA_W   = 48,
   parameter int ADDR_W = 64,
   parameter int SW_LO  = 52
) (
   input logic              clk,
   input logic              rst_n,
   input logic              walk_valid,
   input logic              walk_ready,
   input logic [VA_W-1:0]   walk_va,
   input logic [ADDR_W-1:0] a20_mask,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rsp_valid,
   input logic              done_valid,
   input logic              done_fault,
   input logic              done_large,
   input logic [ADDR_W-1:0] done_pa
);
   logic            outstanding;
   logic [VA_W-1:0] va_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         va_cap      <= '0;
      end else begin
         if (mem_req) outstanding <= 1'b1;
         else if (mem_rsp_valid) outstanding <= 1'b0;
         if (walk_valid && walk_ready) va_cap <= walk_va;
      end
   end

   assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !outstanding);

   assert_req_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !walk_ready);

   assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_fetch_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr & ~a20_mask) == '0 && mem_addr[2:0] == 3'b000));

   assert_pa_no_attr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault) |-> (done_pa[ADDR_W-1:SW_LO] == '0));

   assert_small_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault && !done_large) |-> (done_pa[11:0] == va_cap[11:0]));

   assert_large_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_fault && done_large) |-> (done_pa[20:0] == va_cap[20:0]));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);
endmodule

bind pt_walker pt_walker_chk #(
   .VA_W  (VA_W),
   .ADDR_W(ADDR_W),
   .SW_LO (SW_LO)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .walk_valid   (walk_valid),
   .walk_ready   (walk_ready),
   .walk_va      (walk_va),
   .a20_mask     (a20_mask),
   .mem_req      (mem_req),
   .mem_addr     (mem_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .done_valid   (done_valid),
   .done_fault   (done_fault),
   .done_large   (done_large),
   .done_pa      (done_pa)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [47:0] va;
      logic [63:0] frame;
      logic [63:0] attr;
      logic [2:0]  kind;   // 0 4K, 1 2M, 2 1G fault, 3 top fault, 4 leaf fault, 5 dir fault
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{va: 48'h7F12_3456_789A, frame: 64'h0000_0123_4567_8000, attr: 64'hFFF0_0000_0000_0060, kind: 3'd0},
      '{va: 48'h0000_0000_0FFF, frame: 64'h0000_0000_DEAD_B000, attr: 64'h8000_0000_0000_0000, kind: 3'd0},
      '{va: 48'hFFFF_FFFF_FFFF, frame: 64'h0000_0089_ABC5_6000, attr: 64'h7FF0_0000_0000_0020, kind: 3'd1},
      '{va: 48'h1234_5678_9ABC, frame: 64'h0000_0000_0000_0000, attr: 64'h0000_0000_0000_0000, kind: 3'd2},
      '{va: 48'h8000_0000_0000, frame: 64'h0000_0000_0000_0000, attr: 64'h0000_0000_0000_0000, kind: 3'd3},
      '{va: 48'h0ABC_DEF0_1234, frame: 64'h0000_0055_5555_5000, attr: 64'hFFF0_0000_0000_0000, kind: 3'd4},
      '{va: 48'h0000_4020_1008, frame: 64'h0000_0000_0000_0000, attr: 64'h8010_0000_0000_0000, kind: 3'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        walk_valid = 1'b0;
   logic [47:0] walk_va = '0;
   logic [63:0] root_base = '0;
   logic [63:0] a20_mask = '1;
   logic        walk_ready;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done_valid;
   logic        done_fault;
   logic        done_large;
   logic [63:0] done_pa;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   logic [63:0] mem [logic [63:0]];
   logic [63:0] fetched [4];
   int          nfetch = 0;
   logic        pend = 1'b0;
   logic [63:0] pend_addr = '0;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .walk_valid(walk_valid), .walk_va(walk_va),
      .root_base(root_base), .a20_mask(a20_mask), .walk_ready(walk_ready),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_fault(done_fault),
      .done_large(done_large), .done_pa(done_pa)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model: answers each request one cycle later
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (pend) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
         pend = 1'b0;
      end
      if (mem_req) begin
         pend = 1'b1;
         pend_addr = mem_addr;
         if (nfetch < 4) fetched[nfetch] = mem_addr;
         nfetch = nfetch + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         bad = bad + 1;
         total = total + 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ix8(input logic [47:0] va, input int lvl);
      return 64'(va[12 + 9*lvl +: 9]) << 3;
   endfunction

   task automatic run_walk(input logic [47:0] va, input logic [63:0] root, input logic [63:0] msk,
                           input int busy_pulses, output logic flt, output logic lg,
                           output logic [63:0] pa, output logic saw_done);
      nfetch = 0;
      saw_done = 1'b0;
      @(negedge clk);
      walk_valid = 1'b1; walk_va = va; root_base = root; a20_mask = msk;
      @(negedge clk);
      walk_valid = 1'b0;
      for (int k = 0; k < busy_pulses; k++) begin
         walk_valid = 1'b1; walk_va = ~va; root_base = root ^ 64'h1000;
         @(negedge clk);
      end
      walk_valid = 1'b0;
      for (int c = 0; c < 64 && !saw_done; c++) begin
         if (done_valid) saw_done = 1'b1;
         else @(negedge clk);
      end
      flt = done_fault; lg = done_large; pa = done_pa;
   endtask

   initial begin
      logic flt, lg, saw;
      logic [63:0] pa;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(walk_ready == 1'b1, "R9 ready at reset", 64'(walk_ready), 64'h1);
      chk(mem_req == 1'b0, "R9 no req at reset", 64'(mem_req), 64'h0);
      chk(done_valid == 1'b0, "R9 no done at reset", 64'(done_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [63:0] root, t3, t2, t1, eaddr [4], exp_pa;
         int exp_n;
         logic exp_flt, exp_lg;
         vec_t v;
         v = VEC[i];
         root = 64'h0010_0000 * 64'(i + 1);
         t3 = root + 64'h1000; t2 = root + 64'h2000; t1 = root + 64'h3000;
         eaddr[0] = root + ix8(v.va, 3);
         eaddr[1] = t3 + ix8(v.va, 2);
         eaddr[2] = t2 + ix8(v.va, 1);
         eaddr[3] = t1 + ix8(v.va, 0);
         mem.delete();
         mem[eaddr[0]] = t3 | v.attr | ((v.kind == 3'd3) ? 64'h6 : 64'h7);
         mem[eaddr[1]] = t2 | v.attr | ((v.kind == 3'd2) ? 64'h87 : 64'h7);
         mem[eaddr[2]] = (v.kind == 3'd1) ? (v.frame | v.attr | 64'h87)
                       : (t1 | v.attr | ((v.kind == 3'd5) ? 64'h6 : 64'h7));
         mem[eaddr[3]] = v.frame | v.attr | ((v.kind == 3'd4) ? 64'h6 : 64'h7);
         case (v.kind)
            3'd0: begin exp_n = 4; exp_flt = 0; exp_lg = 0; end
            3'd1: begin exp_n = 3; exp_flt = 0; exp_lg = 1; end
            3'd2: begin exp_n = 2; exp_flt = 1; exp_lg = 0; end
            3'd3: begin exp_n = 1; exp_flt = 1; exp_lg = 0; end
            3'd4: begin exp_n = 4; exp_flt = 1; exp_lg = 0; end
            default: begin exp_n = 3; exp_flt = 1; exp_lg = 0; end
         endcase
         exp_pa = exp_lg ? ((v.frame & ~64'h1F_FFFF) | 64'(v.va[20:0]))
                         : (v.frame | 64'(v.va[11:0]));
         run_walk(v.va, root, '1, 0, flt, lg, pa, saw);
         chk(saw, "R9 done seen", 64'(saw), 64'h1);
         // R4 R7 fault outcome; R5 R6 fetch depth
         chk(flt == exp_flt, "R4/R7 fault flag", 64'(flt), 64'(exp_flt));
         chk(nfetch == exp_n, "R4 R5 R6 R7 fetch count", 64'(nfetch), 64'(exp_n));
         for (int f = 0; f < 4; f++) begin
            if (f < exp_n && f < nfetch)
               chk(fetched[f] == eaddr[f], "R1 R2 R3 fetch address", fetched[f], eaddr[f]);
         end
         if (!exp_flt) begin
            chk(lg == exp_lg, "R5/R6 large flag", 64'(lg), 64'(exp_lg));
            chk(pa == exp_pa, exp_lg ? "R5 large pa" : "R6 small pa R3", pa, exp_pa);
         end
         @(negedge clk);
         chk(done_valid == 1'b0, "R9 done one cycle", 64'(done_valid), 64'h0);
      end

      // R2: address mask removes bit 20 of the fetch address
      begin
         logic [63:0] root, exp_a;
         root = 64'h0030_0000;
         exp_a = (root + ix8(48'h0000_0040_0000, 3)) & ~64'h10_0000;
         mem.delete();
         run_walk(48'h0000_0040_0000, root, ~64'h10_0000, 0, flt, lg, pa, saw);
         chk(fetched[0] == exp_a, "R2 masked fetch address", fetched[0], exp_a);
         chk(nfetch == 1 && flt, "R2 R4 masked walk faults after one fetch", 64'(nfetch), 64'h1);
      end

      // R8: walk_valid while busy is ignored
      begin
         logic [63:0] root, fr, a0, a1, a2, a3, exp_pa;
         logic [47:0] va;
         va = 48'h1357_9BDF_0246;
         root = 64'h0200_0000; fr = 64'h0000_0077_0000_1000;
         a0 = root + ix8(va, 3); a1 = root + 64'h1000 + ix8(va, 2);
         a2 = root + 64'h2000 + ix8(va, 1); a3 = root + 64'h3000 + ix8(va, 0);
         mem.delete();
         mem[a0] = (root + 64'h1000) | 64'h7;
         mem[a1] = (root + 64'h2000) | 64'h7;
         mem[a2] = (root + 64'h3000) | 64'h7;
         mem[a3] = fr | 64'hFFF0_0000_0000_0007;
         @(negedge clk);
         chk(walk_ready == 1'b1, "R8 ready when idle", 64'(walk_ready), 64'h1);
         run_walk(va, root, '1, 3, flt, lg, pa, saw);
         exp_pa = fr | 64'(va[11:0]);
         chk(nfetch == 4, "R8 busy request adds no fetch", 64'(nfetch), 64'h4);
         chk(pa == exp_pa && !flt, "R8 busy request leaves result", pa, exp_pa);
         @(negedge clk);
         chk(walk_ready == 1'b1 && nfetch == 4, "R8 no second walk started", 64'(nfetch), 64'h4);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule